// File: doc/BRIEF.md
# Split Circulant Placement Generator

This block re-expresses one circulant sub-matrix of a quasi-cyclic parity check matrix, originally built for a parallelism of P, as a set of smaller circulants of size Ps = P/S after the matrix is reordered by a split factor S. The sub-matrix is described by one or two diagonal shift values. After a start pulse the block walks through the S split layers, one layer per clock. For every layer it reports which sub-group column each diagonal lands in and the diagonal's shift inside its Ps-sized circulant.

It also flags a conflict whenever both diagonals land in the same sub-group, which means a double diagonal survives the split. A separate combinational port applies the split row/column permutation to any single index. A controller that builds a split base matrix uses these layer results as its entries.

Top module: `split_circ_gen`

## Requirements
- R1: `perm_out` equals (`perm_in` mod S) * Ps + floor(`perm_in` / S), using `cfg_split` as S and `cfg_ps` as Ps, with no clock involved.
- R2: In layer 0 each diagonal with original shift d reports group d mod S and shift floor(d / S).
- R3: From one layer to the next, a diagonal's group rises by one and its shift holds. When the group was S-1, the group returns to 0 and the shift rises by one.
- R4: A shift that rises to Ps wraps to 0.
- R5: `out_valid` is high for exactly S consecutive cycles, beginning the cycle after `start` is sampled. `out_layer` counts 0 to S-1 over those cycles. S may be any value from 1 to 15.
- R6: `done` is a one-cycle pulse in the cycle after the last layer, and it is never high together with `out_valid`.
- R7: With `pair_en` high at start, `conflict` is high in every layer of a run exactly when (d_b - d_a) mod S equals 0.
- R8: With `pair_en` low at start, `conflict` stays low for the whole run.
- R9: A `start` pulse that arrives while a run is in progress is ignored. The run continues with its original shifts and layer count.
- R10: After reset, `out_valid`, `done` and `conflict` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Loads the configuration and shifts, then begins a run |
| cfg_split | input | 4 | Split factor S (1..15) |
| cfg_ps | input | 9 | Circulant size after the split, Ps |
| shift_a | input | 9 | Original shift of the first diagonal |
| shift_b | input | 9 | Original shift of the second diagonal |
| pair_en | input | 1 | Second diagonal present |
| perm_in | input | 9 | Index to permute |
| perm_out | output | 9 | Permuted index |
| out_valid | output | 1 | Layer result valid |
| out_layer | output | 4 | Current split layer |
| grp_a | output | 4 | Sub-group of the first diagonal |
| shf_a | output | 9 | New shift of the first diagonal |
| grp_b | output | 4 | Sub-group of the second diagonal |
| shf_b | output | 9 | New shift of the second diagonal |
| conflict | output | 1 | Both diagonals share a sub-group |
| done | output | 1 | Run finished |

## Verification
The bench checks the group wrap at S-1. A design that forgot the wrap would emit a group index of S or more, and one that forgot to bump the shift would repeat the original shift. It also uses a shift near P so that the bumped shift reaches Ps: a missing modulo would then output Ps itself. S = 1 is covered, where a design with an off-by-one in the layer count would emit zero or two layers. The bench also covers a shift difference that is a multiple of S, where a missed conflict would let a cutting edge pass unseen, and a single-diagonal sub-matrix, where a stray flag would appear. A start pulse sent in the middle of a run would corrupt the scoreboard's expected sequence if the design reloaded on it.

// File: rtl/split_pkg.sv
package split_pkg;
    parameter int MAX_P = 360;
    parameter int MAX_S = 15;
    localparam int IDX_W = $clog2(MAX_P);
    localparam int S_W   = $clog2(MAX_S + 1);

    typedef struct packed {
        logic [S_W-1:0]   grp;
        logic [IDX_W-1:0] shf;
    } place_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/split_divmod.sv
module split_divmod
    import split_pkg::*;
(
    input  logic [IDX_W-1:0] num,
    input  logic [S_W-1:0]   den,
    output logic [IDX_W-1:0] quo,
    output logic [S_W-1:0]   rem
);
    logic [S_W:0] part;

    // restoring long division, one quotient bit per numerator bit
    always_comb begin
        part = '0;
        quo  = '0;
        for (int i = IDX_W - 1; i >= 0; i--) begin
            part = {part[S_W-1:0], num[i]};
            if (part >= {1'b0, den}) begin
                part   = part - {1'b0, den};
                quo[i] = 1'b1;
            end
        end
        rem = part[S_W-1:0];
    end
endmodule

// File: rtl/split_diag_step.sv
module split_diag_step
    import split_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [IDX_W-1:0] shift_in,
    input  logic [S_W-1:0]   split_now,
    input  logic [S_W-1:0]   split_lat,
    input  logic [IDX_W-1:0] ps_lat,
    output place_t           place
);
    logic [IDX_W-1:0] q0;
    logic [S_W-1:0]   r0;
    logic [S_W-1:0]   last_grp;
    logic [IDX_W-1:0] shf_inc;

    split_divmod u_div (
        .num (shift_in),
        .den (split_now),
        .quo (q0),
        .rem (r0)
    );

    assign last_grp = split_lat - S_W'(1);
    assign shf_inc  = place.shf + IDX_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            place <= '0;
        end else if (load) begin
            place.grp <= r0;
            place.shf <= q0;
        end else if (step) begin
            if (place.grp == last_grp) begin
                place.grp <= '0;
                place.shf <= (shf_inc == ps_lat) ? '0 : shf_inc;
            end else begin
                place.grp <= place.grp + S_W'(1);
            end
        end
    end
endmodule

// File: rtl/split_perm_map.sv
module split_perm_map
    import split_pkg::*;
(
    input  logic [IDX_W-1:0] idx_in,
    input  logic [S_W-1:0]   split,
    input  logic [IDX_W-1:0] ps,
    output logic [IDX_W-1:0] idx_out
);
    logic [IDX_W-1:0] q;
    logic [S_W-1:0]   r;

    split_divmod u_div (
        .num (idx_in),
        .den (split),
        .quo (q),
        .rem (r)
    );

    assign idx_out = ({{(IDX_W-S_W){1'b0}}, r} * ps) + q;
endmodule

// File: rtl/split_circ_gen.sv
module split_circ_gen
    import split_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [S_W-1:0]   cfg_split,
    input  logic [IDX_W-1:0] cfg_ps,
    input  logic [IDX_W-1:0] shift_a,
    input  logic [IDX_W-1:0] shift_b,
    input  logic             pair_en,
    input  logic [IDX_W-1:0] perm_in,
    output logic [IDX_W-1:0] perm_out,
    output logic             out_valid,
    output logic [S_W-1:0]   out_layer,
    output logic [S_W-1:0]   grp_a,
    output logic [IDX_W-1:0] shf_a,
    output logic [S_W-1:0]   grp_b,
    output logic [IDX_W-1:0] shf_b,
    output logic             conflict,
    output logic             done
);
    run_state_t       state_q;
    logic [S_W-1:0]   split_q;
    logic [IDX_W-1:0] ps_q;
    logic             pair_q;
    logic [S_W-1:0]   layer_q;
    logic             done_q;
    logic             accept;
    logic             at_last;
    logic             advance;

    logic [IDX_W-1:0] shifts [2];
    place_t           places [2];

    assign accept  = start && (state_q == ST_IDLE);
    assign at_last = (layer_q == split_q - S_W'(1));
    assign advance = (state_q == ST_RUN) && !at_last;
    assign shifts[0] = shift_a;
    assign shifts[1] = shift_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            split_q <= S_W'(1);
            ps_q    <= IDX_W'(1);
            pair_q  <= 1'b0;
            layer_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state_q <= ST_RUN;
                split_q <= cfg_split;
                ps_q    <= cfg_ps;
                pair_q  <= pair_en;
                layer_q <= '0;
            end else if (state_q == ST_RUN) begin
                if (at_last) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    layer_q <= layer_q + S_W'(1);
                end
            end
        end
    end

    for (genvar d = 0; d < 2; d++) begin : g_diag
        split_diag_step u_step (
            .clk       (clk),
            .rst       (rst),
            .load      (accept),
            .step      (advance),
            .shift_in  (shifts[d]),
            .split_now (cfg_split),
            .split_lat (split_q),
            .ps_lat    (ps_q),
            .place     (places[d])
        );
    end

    split_perm_map u_perm (
        .idx_in  (perm_in),
        .split   (cfg_split),
        .ps      (cfg_ps),
        .idx_out (perm_out)
    );

    assign out_valid = (state_q == ST_RUN);
    assign out_layer = layer_q;
    assign grp_a     = places[0].grp;
    assign shf_a     = places[0].shf;
    assign grp_b     = places[1].grp;
    assign shf_b     = places[1].shf;
    assign conflict  = out_valid && pair_q && (places[0].grp == places[1].grp);
    assign done      = done_q;
endmodule

// File: rtl/split_circ_gen_chk.sv
module split_circ_gen_chk
    import split_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             out_valid,
    input logic [S_W-1:0]   out_layer,
    input logic [S_W-1:0]   grp_a,
    input logic [IDX_W-1:0] shf_a,
    input logic [S_W-1:0]   grp_b,
    input logic             conflict,
    input logic             done
);
    // R5
    layer_step_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> (out_layer == $past(out_layer) + S_W'(1)));

    // R6
    done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(out_valid));

    // R6
    done_alone_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);

    // R7
    conflict_shape_chk: assert property (@(posedge clk) disable iff (rst)
        conflict |-> (out_valid && grp_a == grp_b));

    // R3
    group_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid) && grp_a != '0)
            |-> (grp_a == $past(grp_a) + S_W'(1) && $stable(shf_a)));
endmodule

bind split_circ_gen split_circ_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_layer (out_layer),
    .grp_a     (grp_a),
    .shf_a     (shf_a),
    .grp_b     (grp_b),
    .conflict  (conflict),
    .done      (done)
);

// File: tb/sim_split_circ_gen.sv
module sim_split_circ_gen;
    import split_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [S_W-1:0]   cfg_split = S_W'(1);
    logic [IDX_W-1:0] cfg_ps = IDX_W'(1);
    logic [IDX_W-1:0] shift_a = '0, shift_b = '0, perm_in = '0;
    logic pair_en = 1'b0;
    logic [IDX_W-1:0] perm_out, shf_a, shf_b;
    logic [S_W-1:0]   out_layer, grp_a, grp_b;
    logic out_valid, conflict, done;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit pend_done = 0;

    typedef struct {
        int layer; int ga; int sa; int gb; int sb; bit conf; bit last; string tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    split_circ_gen u0 (
        .clk(clk), .rst(rst), .start(start), .cfg_split(cfg_split), .cfg_ps(cfg_ps),
        .shift_a(shift_a), .shift_b(shift_b), .pair_en(pair_en), .perm_in(perm_in),
        .perm_out(perm_out), .out_valid(out_valid), .out_layer(out_layer),
        .grp_a(grp_a), .shf_a(shf_a), .grp_b(grp_b), .shf_b(shf_b),
        .conflict(conflict), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: pops the scoreboard away from the clock edge
    always @(negedge clk) begin
        if (!rst) begin
            if (pend_done || done) check(done == pend_done, "R6 done pulse", done, pend_done);
            pend_done = 0;
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    check(0, "R5 unexpected layer", out_layer, -1);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(out_layer == e.layer, {"R5 layer ", e.tag}, out_layer, e.layer);
                    check(grp_a == e.ga, {"R2/R3 grp_a ", e.tag}, grp_a, e.ga);
                    check(shf_a == e.sa, {"R2/R3/R4 shf_a ", e.tag}, shf_a, e.sa);
                    check(grp_b == e.gb, {"R2/R3 grp_b ", e.tag}, grp_b, e.gb);
                    check(shf_b == e.sb, {"R2/R3/R4 shf_b ", e.tag}, shf_b, e.sb);
                    check(conflict == e.conf, {"R7/R8 conflict ", e.tag}, conflict, e.conf);
                    pend_done = e.last;
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 50000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // driver: pushes the expected layers, then pulses start
    task automatic run_case(input int s, input int ps, input int da, input int db,
                            input bit two, input string tag, input bit poke);
        bit cf;
        cf = two && ((((db - da) % s) + s) % s == 0);
        for (int l = 0; l < s; l++) begin
            exp_t e;
            e.layer = l;
            e.ga = (da + l) % s; e.sa = ((da + l) / s) % ps;
            e.gb = (db + l) % s; e.sb = ((db + l) / s) % ps;
            e.conf = cf; e.last = (l == s - 1); e.tag = tag;
            sb_q.push_back(e);
        end
        @(posedge clk); #1;
        cfg_split = S_W'(s); cfg_ps = IDX_W'(ps);
        shift_a = IDX_W'(da); shift_b = IDX_W'(db); pair_en = two; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (poke) begin
            // R9: a second start during the run must not reload
            @(posedge clk); #1;
            cfg_split = S_W'(2); shift_a = IDX_W'(1); shift_b = IDX_W'(5); start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
        end
        while (sb_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        check(pend_done == 0, {"R9 no extra layers ", tag}, out_valid, 0);
    endtask

    task automatic perm_case(input int s, input int ps, input int i);
        int expv;
        @(negedge clk);
        cfg_split = S_W'(s); cfg_ps = IDX_W'(ps); perm_in = IDX_W'(i);
        #1;
        expv = (i % s) * ps + i / s;
        check(perm_out == IDX_W'(expv), "R1 permutation", perm_out, expv);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(out_valid == 0, "R10 reset valid", out_valid, 0);
        check(done == 0, "R10 reset done", done, 0);
        check(conflict == 0, "R10 reset conflict", conflict, 0);

        perm_case(3, 4, 0);
        perm_case(3, 4, 7);
        perm_case(3, 4, 11);
        perm_case(8, 45, 359);
        perm_case(8, 45, 100);
        perm_case(1, 360, 200);

        run_case(3, 4, 2, 6, 1'b1, "R2 example", 1'b0);
        run_case(3, 4, 11, 5, 1'b1, "R4 wrap", 1'b0);
        run_case(3, 4, 1, 7, 1'b1, "R7 conflict", 1'b0);
        run_case(3, 4, 1, 7, 1'b0, "R8 single", 1'b0);
        run_case(1, 360, 359, 0, 1'b1, "R5 S1", 1'b0);
        run_case(15, 24, 359, 14, 1'b1, "R5 S15", 1'b0);
        run_case(8, 45, 300, 17, 1'b1, "R9 busy", 1'b1);
        run_case(10, 36, 357, 7, 1'b1, "R3 mixed", 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule